// File: doc/BRIEF.md
# Oversampled Serial Receiver with Start-Bit Qualification

This block is the receive half of a full-duplex asynchronous serial port. It runs beside an independent transmitter and shares nothing with it. A bit-rate enable arrives from an external divider at sixteen pulses per bit time. The block watches a synchronized copy of the serial input, treats a low level only as a start candidate, and confirms the candidate half a bit later. It then assembles a character of five to eight data bits, least significant bit first. An optional parity bit follows, and a stop bit closes the frame.

Each completed character is placed in a single-entry holding register together with its parity-error and framing-error flags. The holding register is offered on a valid/ready output. `rx_valid` rises when a character is loaded and stays high, with `rx_data` and the flags unchanged, until the consumer accepts with `rx_ready` high on a clock edge. There is no back-pressure toward the serial line. If a character completes while the holding register is still full and is not accepted on that same edge, the new character is discarded and the overrun flag is raised. Clearing `rx_en` stops new characters from starting, but a character already being assembled still runs to the end.

Top module: `serial_rx`

## Requirements
- R1: After reset, `rx_valid`, `err_parity`, `err_frame`, `err_overrun` and `rx_busy` are all 0.
- R2: A low line is confirmed as a start bit only if it is still low on the 8th bit-rate pulse after detection. A shorter low pulse, including one right after a stop bit, is rejected: the receiver goes back to idle and loads nothing.
- R3: Data bits arrive least significant bit first. `word_len` sets the character width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of `rx_data` read as 0.
- R4: When `par_en` is 1, one parity bit follows the data bits. When `par_odd` is 1, the data bits plus the parity bit must hold an odd number of ones; when it is 0, the count must be even. A mismatch sets `err_parity`, and the parity bit never appears in `rx_data`.
- R5: A low line at the stop-bit sample sets `err_frame`, and the character is still loaded.
- R6: `rx_valid` and `rx_data` hold steady while `rx_ready` is 0. An edge with both high clears `rx_valid`.
- R7: If a character completes while `rx_valid` is 1 and no acceptance happens on that edge, `err_overrun` is set and the held data is kept. The next character that loads successfully clears `err_overrun`.
- R8: While `rx_en` is 0 no new start is taken. A character already in progress when `rx_en` falls is completed and loaded.
- R9: `rx_busy` is 1 from start detection until the frame ends or the start candidate is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Bit-rate enable, OVERSAMPLE pulses per bit |
| rx_en | input | 1 | Receive enable |
| word_len | input | 2 | Character width code (width = 5 + code) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rxd | input | 1 | Serial input line, idle high |
| rx_ready | input | 1 | Consumer accepts the held character |
| rx_valid | output | 1 | Holding register full |
| rx_data | output | 8 | Received character, right aligned |
| err_parity | output | 1 | Parity error of the held character |
| err_frame | output | 1 | Framing error of the held character |
| err_overrun | output | 1 | A character was lost to a full register |
| rx_busy | output | 1 | Receiver is inside a frame or a start candidate |

## Verification
The bench uses the default parameters: 16x oversampling, 8-bit data and a two-stage input synchronizer. It pulses `tick` on every second clock, so each bit lasts 32 clocks and there are idle clocks between enables. These settings cover all four character widths, both parity senses and a bad stop bit. They also allow a glitch placed right after a bad stop bit and a standalone glitch that lasts under half a bit. With a 32-clock bit time the bench can also overlap completion with a full register, and it can drop the enable partway through a frame.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic enable;
    logic odd;
  } par_cfg_t;

endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxs_frame.sv
module rxs_frame
  import rxs_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int DW   = 8,
  parameter int MINW = 5,
  parameter int WLW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_en,
  input  logic          line,
  input  logic [WLW-1:0] word_len,
  input  par_cfg_t      par_cfg,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] bidx;
  logic [IW-1:0] last_idx;
  logic [DW-1:0] shreg;
  logic          ones_acc;
  logic          perr_pend;
  par_cfg_t      cfg_q;
  logic [IW-1:0] align;

  assign align = IW'(DW - 1) - last_idx;
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      last_idx  <= '0;
      shreg     <= '0;
      ones_acc  <= 1'b0;
      perr_pend <= 1'b0;
      cfg_q     <= '0;
      done      <= 1'b0;
      data_o    <= '0;
      perr_o    <= 1'b0;
      ferr_o    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (rx_en && !line) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!line) begin
                state     <= ST_DATA;
                bidx      <= '0;
                last_idx  <= IW'(MINW - 1) + IW'(word_len);
                cfg_q     <= par_cfg;
                ones_acc  <= 1'b0;
                perr_pend <= 1'b0;
                shreg     <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == LAST) begin
              cnt      <= '0;
              shreg    <= {line, shreg[DW-1:1]};
              ones_acc <= ones_acc ^ line;
              if (bidx == last_idx) begin
                state <= cfg_q.enable ? ST_PAR : ST_STOP;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == LAST) begin
              cnt       <= '0;
              perr_pend <= ones_acc ^ line ^ cfg_q.odd;
              state     <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == LAST) begin
              cnt    <= '0;
              state  <= ST_IDLE;
              done   <= 1'b1;
              data_o <= shreg >> align;
              perr_o <= cfg_q.enable & perr_pend;
              ferr_o <= ~line;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R8: with the enable low an idle receiver stays idle
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !rx_en) |=> (state == ST_IDLE));

  // R2: a candidate that is high at the mid-bit check returns to idle without completing
  p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && tick && cnt == MID && line) |=> (state == ST_IDLE && !done));

  // R9: a completion pulse lasts one cycle and leaves the receiver idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(state) == ST_STOP));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rxs_hold.sv
module rxs_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          perr_in,
  input  logic          ferr_in,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] dout,
  output logic          perr,
  output logic          ferr,
  output logic          ovr
);
  logic accept;
  assign accept = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
    end else if (load) begin
      if (valid && !accept) begin
        ovr <= 1'b1;
      end else begin
        valid <= 1'b1;
        dout  <= din;
        perr  <= perr_in;
        ferr  <= ferr_in;
        ovr   <= 1'b0;
      end
    end else if (accept) begin
      valid <= 1'b0;
    end
  end

  // R6: an unaccepted character stays offered and unchanged
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));

  // R6: acceptance without a new character empties the register
  p_accept_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid);

  // R7: a completion into a full, unaccepted register flags overrun and keeps the data
  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && valid && !ready) |=> (ovr && $stable(dout)));
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import rxs_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int MIN_BITS    = 5,
  parameter int SYNC_STAGES = 2,
  localparam int WL_W = $clog2(DATA_BITS - MIN_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx_en,
  input  logic [WL_W-1:0]      word_len,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 rxd,
  input  logic                 rx_ready,
  output logic                 rx_valid,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 err_parity,
  output logic                 err_frame,
  output logic                 err_overrun,
  output logic                 rx_busy
);
  logic                 line_s;
  logic                 fr_done;
  logic [DATA_BITS-1:0] fr_data;
  logic                 fr_perr;
  logic                 fr_ferr;
  par_cfg_t             pcfg;

  assign pcfg.enable = par_en;
  assign pcfg.odd    = par_odd;

  rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s)
  );

  rxs_frame #(
    .OVS (OVERSAMPLE),
    .DW  (DATA_BITS),
    .MINW(MIN_BITS),
    .WLW (WL_W)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rx_en   (rx_en),
    .line    (line_s),
    .word_len(word_len),
    .par_cfg (pcfg),
    .busy    (rx_busy),
    .done    (fr_done),
    .data_o  (fr_data),
    .perr_o  (fr_perr),
    .ferr_o  (fr_ferr)
  );

  rxs_hold #(.DW(DATA_BITS)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (fr_done),
    .din    (fr_data),
    .perr_in(fr_perr),
    .ferr_in(fr_ferr),
    .ready  (rx_ready),
    .valid  (rx_valid),
    .dout   (rx_data),
    .perr   (err_parity),
    .ferr   (err_frame),
    .ovr    (err_overrun)
  );

  // R1: nothing is offered or flagged in the cycle after reset is released
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rx_valid && !err_overrun && !rx_busy));

  // R3: an empty register only fills on a completed frame
  p_fill_needs_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !fr_done) |=> !rx_valid);
endmodule

// File: tb/serial_rx_test.sv
module serial_rx_test;
  localparam int BITCLK = 32;

  typedef struct packed {
    logic [7:0] din;
    logic [1:0] wl;
    logic       pen;
    logic       podd;
    logic       pflip;
    logic       sbad;
    logic [7:0] exp;
    logic       eperr;
    logic       eferr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    '{8'h3C, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1C, 1'b0, 1'b0},
    '{8'hFF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3F, 1'b0, 1'b0},
    '{8'h55, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
    '{8'h96, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0},
    '{8'h96, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h96, 1'b1, 1'b0},
    '{8'h0F, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, 1'b0, 1'b0},
    '{8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1},
    '{8'h12, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h12, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx_en = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_ready = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       err_parity;
  logic       err_frame;
  logic       err_overrun;
  logic       rx_busy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  serial_rx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en),
    .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
    .rxd(rxd), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .rx_busy(rx_busy)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] wl,
                            input logic pen, input logic podd,
                            input logic pflip, input logic sbad);
    logic [7:0] m;
    logic pb;
    int nb;
    nb = 5 + int'(wl);
    m  = 8'hFF >> (8 - nb);
    pb = (^(d & m)) ^ podd ^ pflip;
    word_len = wl;
    par_en   = pen;
    par_odd  = podd;
    rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    if (pen) begin
      rxd = pb;
      repeat (BITCLK) @(negedge clk);
    end
    if (sbad) begin
      rxd = 1'b0;
      repeat (26) @(negedge clk);
      rxd = 1'b1;
      repeat (BITCLK - 26) @(negedge clk);
    end else begin
      rxd = 1'b1;
      repeat (BITCLK) @(negedge clk);
    end
  endtask

  task automatic accept;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "valid", {7'd0, rx_valid}, 8'd0);
    check("R1", "busy", {7'd0, rx_busy}, 8'd0);
    check("R1", "flags", {5'd0, err_parity, err_frame, err_overrun}, 8'd0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (40) @(negedge clk);

    // R3 R4 R5 table walk
    for (int v = 0; v < NV; v++) begin
      send_frame(VECS[v].din, VECS[v].wl, VECS[v].pen, VECS[v].podd,
                 VECS[v].pflip, VECS[v].sbad);
      check("R3", "valid", {7'd0, rx_valid}, 8'd1);
      check("R3", "data", rx_data, VECS[v].exp);
      check("R4", "parity", {7'd0, err_parity}, {7'd0, VECS[v].eperr});
      check("R5", "frame", {7'd0, err_frame}, {7'd0, VECS[v].eferr});
      accept();
      check("R6", "valid after accept", {7'd0, rx_valid}, 8'd0);
      repeat (40) @(negedge clk);
      // R2: glitch after a bad stop bit loads nothing
      check("R2", "no stray load", {7'd0, rx_valid}, 8'd0);
    end

    // R2 R9: short glitch
    rxd = 1'b0;
    repeat (10) @(negedge clk);
    check("R9", "busy in candidate", {7'd0, rx_busy}, 8'd1);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check("R2", "glitch idle", {7'd0, rx_busy}, 8'd0);
    check("R2", "glitch no load", {7'd0, rx_valid}, 8'd0);

    // R7: overrun
    send_frame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check("R6", "held valid", {7'd0, rx_valid}, 8'd1);
    send_frame(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7", "overrun", {7'd0, err_overrun}, 8'd1);
    check("R7", "old data kept", rx_data, 8'h5A);
    accept();
    send_frame(8'h3E, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7", "overrun cleared", {7'd0, err_overrun}, 8'd0);
    check("R7", "new data", rx_data, 8'h3E);
    accept();
    repeat (20) @(negedge clk);

    // R8: disabled receiver ignores a frame
    rx_en = 1'b0;
    send_frame(8'h77, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check("R8", "no load while disabled", {7'd0, rx_valid}, 8'd0);
    check("R8", "idle while disabled", {7'd0, rx_busy}, 8'd0);

    // R8: disable mid-frame still completes
    rx_en = 1'b1;
    fork
      send_frame(8'hB4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
      begin
        repeat (100) @(negedge clk);
        rx_en = 1'b0;
      end
    join
    check("R8", "in-flight completes", {7'd0, rx_valid}, 8'd1);
    check("R8", "in-flight data", rx_data, 8'hB4);
    accept();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule